// File: doc/BRIEF.md
# Debug peripheral freeze controller

This block holds one freeze flag for each on-chip peripheral and drives one freeze line per peripheral. Software freezes peripherals by writing ones to a set register and releases them by writing ones to a clear register. Zero bits in either write leave their flags as they are, so independent software agents can change their own peripherals without a read-modify-write sequence.

A second source of freeze comes from the debug side. While the system CPU or the coprocessor CPU reports a debug halt, and the enable bit for that CPU is set, every peripheral line is forced to freeze. The system watchdog is a special case: it is always frozen while the system CPU is halted, whatever that enable says. Forced freezing is ORed onto the lines and never changes the stored software flags. A software freeze of the system watchdog is refused while the watchdog is configured for its NMI/reset mode.

All registers sit on a simple word-addressed bus that has an address, a write strobe, write data and registered read data. The freeze lines are registered, and the block has a synchronous active-high reset.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: A write to byte offset 0x0 sets every software freeze flag whose write-data bit is 1 and leaves the flags for 0 bits unchanged.
- R2: A write to byte offset 0x4 clears every software freeze flag whose write-data bit is 1 and leaves the flags for 0 bits unchanged.
- R3: Line index 2 is reserved. It reads as 0, ignores writes and its freeze line stays 0. Read-data bits 31:11 are always 0. Line indices are 0 wake-up timer, 1 timer 1, 3 system watchdog, 4 USB, 5 DMA, 6 timer 2, 7 PWM LED, 8 timer 3, 9 timer 4 and 10 coprocessor watchdog.
- R4: A set write to bit 3 (system watchdog) has no effect while `wdog_nmi_mode` is 1. Clearing bit 3 works in either mode.
- R5: The system-CPU enable is bit 0 of the debug register at offset 0x8 and resets to 1. While it is 1 and `sys_halted` is 1, all ten non-reserved lines are frozen.
- R6: While `sys_halted` is 1, line 3 is frozen even when the system-CPU enable is 0.
- R7: The coprocessor enable is bit 1 of the debug register and resets to 0. While it is 1 and `cop_halted` is 1, all ten non-reserved lines are frozen.
- R8: After reset all software flags and freeze lines are 0, the debug register reads 0x1, and the read data is 0.
- R9: Each freeze line is the OR of its software flag and the active halt terms. A halt does not change the software flags that are read back from offsets 0x0 and 0x4.
- R10: A freeze line reflects a write or a halt change on the clock edge that samples it. The read data presents the register selected by the address sampled at an edge, with its value from before that edge's write.
- R11: Offsets 0x0 and 0x4 both read the software flags, and offset 0x8 reads the two enable bits. Offset 0xC, and any address with its low two bits non-zero, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_halted | input | 1 | System CPU is halted in debug |
| cop_halted | input | 1 | Coprocessor CPU is halted in debug |
| wdog_nmi_mode | input | 1 | System watchdog is in NMI/reset mode; blocks its software freeze |
| frz_out | output | 11 | Freeze line per peripheral, registered |

## Verification
The bench aims at the points where the two freeze sources meet. A halt while software flags are set must leave the read-back flags untouched after the halt drops; a design that stores the forced freeze would keep peripherals frozen after resume. With the system enable cleared, a halt must freeze only the watchdog; a design that gates that line by the enable would let the watchdog expire during a debug session. A set write with all ones in NMI mode must skip bit 3 and the reserved bit; getting this wrong shows up as a frozen watchdog or a non-zero bit 2. A long random phase that mixes writes, halts and mode changes is compared every cycle against a behavioural model, and this exposes any off-by-one-cycle timing on the lines or on the read data.

// File: rtl/dbg_freeze_pkg.sv
package dbg_freeze_pkg;

  typedef enum logic [1:0] {
    SEL_SET   = 2'd0,
    SEL_CLR   = 2'd1,
    SEL_DBG   = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  localparam int unsigned EN_W   = 2;
  localparam int unsigned EN_SYS = 0;
  localparam int unsigned EN_COP = 1;
  localparam logic [EN_W-1:0] EN_RESET = 2'b01;

endpackage

// File: rtl/frz_sw_state.sv
module frz_sw_state #(
  parameter int unsigned NUM_PERIPH = 11,
  parameter int unsigned RSVD_BIT   = 2,
  parameter int unsigned WDOG_BIT   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_stb,
  input  logic                  clr_stb,
  input  logic                  wdog_block,
  input  logic [NUM_PERIPH-1:0] wmask,
  output logic [NUM_PERIPH-1:0] sw_d,
  output logic [NUM_PERIPH-1:0] sw_q
);

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
    if (i == RSVD_BIT) begin : g_rsvd
      assign sw_d[i] = 1'b0;
    end else if (i == WDOG_BIT) begin : g_wdog
      logic take_set;
      assign take_set = set_stb && wmask[i] && !wdog_block;
      always_comb begin
        sw_d[i] = sw_q[i];
        if (take_set)              sw_d[i] = 1'b1;
        else if (clr_stb && wmask[i]) sw_d[i] = 1'b0;
      end
    end else begin : g_norm
      always_comb begin
        sw_d[i] = sw_q[i];
        if (set_stb && wmask[i])      sw_d[i] = 1'b1;
        else if (clr_stb && wmask[i]) sw_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sw_q <= '0;
    else     sw_q <= sw_d;
  end

endmodule

// File: rtl/frz_dbg_enable.sv
module frz_dbg_enable
  import dbg_freeze_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  logic [EN_W-1:0] wbits,
  output logic [EN_W-1:0] en_d,
  output logic [EN_W-1:0] en_q
);

  assign en_d = wr_stb ? wbits : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= EN_RESET;
    else     en_q <= en_d;
  end

endmodule

// File: rtl/frz_halt_gate.sv
module frz_halt_gate
  import dbg_freeze_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 11,
  parameter int unsigned RSVD_BIT   = 2,
  parameter int unsigned WDOG_BIT   = 3
) (
  input  logic [NUM_PERIPH-1:0] sw_d,
  input  logic [EN_W-1:0]       en_d,
  input  logic                  sys_halted,
  input  logic                  cop_halted,
  output logic [NUM_PERIPH-1:0] frz_d
);

  logic sys_all;
  logic cop_all;

  assign sys_all = sys_halted && en_d[EN_SYS];
  assign cop_all = cop_halted && en_d[EN_COP];

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_line
    if (i == RSVD_BIT) begin : g_rsvd
      assign frz_d[i] = 1'b0;
    end else if (i == WDOG_BIT) begin : g_wdog
      assign frz_d[i] = sw_d[i] || sys_halted || cop_all;
    end else begin : g_norm
      assign frz_d[i] = sw_d[i] || sys_all || cop_all;
    end
  end

endmodule

// File: rtl/frz_readback.sv
module frz_readback
  import dbg_freeze_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 11,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel_ok,
  input  reg_sel_e              sel,
  input  logic [NUM_PERIPH-1:0] sw_q,
  input  logic [EN_W-1:0]       en_q,
  output logic [DATA_W-1:0]     rdata
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (sel_ok) begin
      case (sel)
        SEL_SET, SEL_CLR: rd_mux = {{(DATA_W-NUM_PERIPH){1'b0}}, sw_q};
        SEL_DBG:          rd_mux = {{(DATA_W-EN_W){1'b0}}, en_q};
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
  import dbg_freeze_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 11,
  parameter int unsigned RSVD_BIT   = 2,
  parameter int unsigned WDOG_BIT   = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  sys_halted,
  input  logic                  cop_halted,
  input  logic                  wdog_nmi_mode,
  output logic [NUM_PERIPH-1:0] frz_out
);

  logic                  sel_ok;
  reg_sel_e              sel;
  logic [NUM_PERIPH-1:0] sw_d;
  logic [NUM_PERIPH-1:0] sw_q;
  logic [EN_W-1:0]       en_d;
  logic [EN_W-1:0]       en_q;
  logic [NUM_PERIPH-1:0] frz_d;
  logic                  unused_wdata_hi;

  assign sel_ok = (bus_addr[1:0] == 2'b00);
  assign sel    = reg_sel_e'(bus_addr[3:2]);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PERIPH];

  frz_sw_state #(
    .NUM_PERIPH(NUM_PERIPH),
    .RSVD_BIT  (RSVD_BIT),
    .WDOG_BIT  (WDOG_BIT)
  ) u_state (
    .clk       (clk),
    .rst       (rst),
    .set_stb   (bus_wr && sel_ok && sel == SEL_SET),
    .clr_stb   (bus_wr && sel_ok && sel == SEL_CLR),
    .wdog_block(wdog_nmi_mode),
    .wmask     (bus_wdata[NUM_PERIPH-1:0]),
    .sw_d      (sw_d),
    .sw_q      (sw_q)
  );

  frz_dbg_enable u_en (
    .clk   (clk),
    .rst   (rst),
    .wr_stb(bus_wr && sel_ok && sel == SEL_DBG),
    .wbits (bus_wdata[EN_W-1:0]),
    .en_d  (en_d),
    .en_q  (en_q)
  );

  frz_halt_gate #(
    .NUM_PERIPH(NUM_PERIPH),
    .RSVD_BIT  (RSVD_BIT),
    .WDOG_BIT  (WDOG_BIT)
  ) u_gate (
    .sw_d      (sw_d),
    .en_d      (en_d),
    .sys_halted(sys_halted),
    .cop_halted(cop_halted),
    .frz_d     (frz_d)
  );

  frz_readback #(
    .NUM_PERIPH(NUM_PERIPH),
    .DATA_W    (DATA_W)
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel_ok(sel_ok),
    .sel   (sel),
    .sw_q  (sw_q),
    .en_q  (en_q),
    .rdata (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) frz_out <= '0;
    else     frz_out <= frz_d;
  end

endmodule

// File: rtl/dbg_freeze_ctrl_chk.sv
module dbg_freeze_ctrl_chk #(
  parameter int unsigned NUM_PERIPH = 11,
  parameter int unsigned RSVD_BIT   = 2,
  parameter int unsigned WDOG_BIT   = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic                  sys_halted,
  input logic                  cop_halted,
  input logic                  wdog_nmi_mode,
  input logic [NUM_PERIPH-1:0] frz_out,
  input logic [NUM_PERIPH-1:0] sw_q,
  input logic [1:0]            en_q
);

  localparam logic [NUM_PERIPH-1:0] LIVE = ~(NUM_PERIPH'(1) << RSVD_BIT);

  logic was_rst = 1'b0;
  always_ff @(posedge clk) was_rst <= rst;

  // R8: one edge after a reset cycle everything is cleared
  always @(negedge clk) begin
    if (was_rst && !rst) begin
      a_r8_reset_state: assert (frz_out == '0 && bus_rdata == '0 && sw_q == '0 && en_q == 2'b01);
    end
  end

  logic set_wr;
  logic clr_wr;
  assign set_wr = bus_wr && bus_addr == 4'h0;
  assign clr_wr = bus_wr && bus_addr == 4'h4;

  a_r1_set_bits: assert property (@(posedge clk) disable iff (rst)
    set_wr && !wdog_nmi_mode |=>
      ((sw_q & $past(bus_wdata[NUM_PERIPH-1:0] & LIVE)) == $past(bus_wdata[NUM_PERIPH-1:0] & LIVE)));

  a_r2_clear_bits: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((sw_q & $past(bus_wdata[NUM_PERIPH-1:0])) == '0));

  a_r3_reserved_low: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (!frz_out[RSVD_BIT] && !sw_q[RSVD_BIT] && bus_rdata[DATA_W-1:NUM_PERIPH] == '0));

  a_r4_wdog_blocked: assert property (@(posedge clk) disable iff (rst)
    set_wr && wdog_nmi_mode && !sw_q[WDOG_BIT] |=> !sw_q[WDOG_BIT]);

  a_r5_sys_all: assert property (@(posedge clk) disable iff (rst)
    sys_halted && en_q[0] && !bus_wr |=> (frz_out == LIVE));

  a_r6_wdog_on_halt: assert property (@(posedge clk) disable iff (rst)
    sys_halted |=> frz_out[WDOG_BIT]);

  a_r7_cop_all: assert property (@(posedge clk) disable iff (rst)
    cop_halted && en_q[1] && !bus_wr |=> (frz_out == LIVE));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(sw_q));

endmodule

bind dbg_freeze_ctrl dbg_freeze_ctrl_chk #(
  .NUM_PERIPH(NUM_PERIPH),
  .RSVD_BIT  (RSVD_BIT),
  .WDOG_BIT  (WDOG_BIT),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .sys_halted   (sys_halted),
  .cop_halted   (cop_halted),
  .wdog_nmi_mode(wdog_nmi_mode),
  .frz_out      (frz_out),
  .sw_q         (sw_q),
  .en_q         (en_q)
);

// File: tb/dbg_freeze_ctrl_test.sv
`timescale 1ns/1ps
module dbg_freeze_ctrl_test;

  localparam int LIVE = 32'h7FB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_halted = 1'b0;
  logic        cop_halted = 1'b0;
  logic        wdog_nmi_mode = 1'b0;
  logic [10:0] frz_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R8";

  int m_sw = 0, m_en = 1, m_frz = 0, m_rd = 0;

  always #4 clk = ~clk;

  dbg_freeze_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_halted(sys_halted),
    .cop_halted(cop_halted), .wdog_nmi_mode(wdog_nmi_mode), .frz_out(frz_out)
  );

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    int nsw, nen, f, rd;
    if (rst) begin
      m_sw = 0; m_en = 1; m_frz = 0; m_rd = 0;
    end else begin
      nsw = m_sw; nen = m_en; rd = 0;
      if (bus_addr == 4'h0 || bus_addr == 4'h4) rd = m_sw;
      else if (bus_addr == 4'h8) rd = m_en;
      if (bus_wr) begin
        if (bus_addr == 4'h0)
          nsw = nsw | (int'(bus_wdata) & LIVE & (wdog_nmi_mode ? ~8 : ~0));
        else if (bus_addr == 4'h4)
          nsw = nsw & ~int'(bus_wdata);
        else if (bus_addr == 4'h8)
          nen = int'(bus_wdata) & 3;
      end
      nsw = nsw & LIVE;
      f = nsw;
      if (sys_halted) f = f | 8;
      if (sys_halted && nen[0]) f = f | LIVE;
      if (cop_halted && nen[1]) f = f | LIVE;
      m_sw = nsw; m_en = nen; m_frz = f; m_rd = rd;
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(frz_out) != m_frz) begin
        failures++;
        $display("FAIL %s frz_out actual=%h expected=%h", cur_req, frz_out, m_frz[10:0]);
      end
      checks++;
      if (int'(bus_rdata) != m_rd) begin
        failures++;
        $display("FAIL %s bus_rdata actual=%h expected=%h", cur_req, bus_rdata, m_rd);
      end
    end
  end

  task automatic expect_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // select a register, return its read data one edge later
  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    cur_req = "R8";
    expect_val("R8", int'(frz_out), 0);
    rd(4'h8, v); expect_val("R8", v, 1);
    rd(4'h0, v); expect_val("R8", v, 0);

    cur_req = "R1";
    wr(4'h0, 32'h0A3);
    expect_val("R10", int'(frz_out), 32'h0A3);
    wr(4'h0, 32'h100);
    rd(4'h0, v); expect_val("R1", v, 32'h1A3);

    cur_req = "R3";
    wdog_nmi_mode = 1'b1;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h4, v); expect_val("R4", v, 32'h7F3);
    expect_val("R3", int'(frz_out[2]), 0);

    cur_req = "R2";
    wr(4'h4, 32'h0F0);
    rd(4'h4, v); expect_val("R2", v, 32'h703);

    cur_req = "R4";
    wr(4'h0, 32'h8);
    rd(4'h0, v); expect_val("R4", v, 32'h703);
    wdog_nmi_mode = 1'b0;
    wr(4'h0, 32'h8);
    rd(4'h0, v); expect_val("R4", v, 32'h70B);
    wdog_nmi_mode = 1'b1;
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h0, v); expect_val("R4", v, 0);
    wdog_nmi_mode = 1'b0;

    cur_req = "R11";
    wr(4'hC, 32'h7FF);
    wr(4'h1, 32'h7FF);
    rd(4'hC, v); expect_val("R11", v, 0);
    rd(4'h0, v); expect_val("R11", v, 0);

    cur_req = "R5";
    wr(4'h0, 32'h002);
    @(negedge clk); sys_halted = 1'b1;
    @(negedge clk); expect_val("R5", int'(frz_out), LIVE);
    cur_req = "R9";
    rd(4'h0, v); expect_val("R9", v, 32'h002);
    @(negedge clk); sys_halted = 1'b0;
    @(negedge clk); expect_val("R9", int'(frz_out), 32'h002);
    wr(4'h4, 32'h002);

    cur_req = "R6";
    wr(4'h8, 32'h0);
    @(negedge clk); sys_halted = 1'b1;
    @(negedge clk); expect_val("R6", int'(frz_out), 32'h008);
    @(negedge clk); sys_halted = 1'b0;
    idle(2);

    cur_req = "R7";
    rd(4'h8, v); expect_val("R7", v, 0);
    @(negedge clk); cop_halted = 1'b1;
    @(negedge clk); expect_val("R7", int'(frz_out), 0);
    wr(4'h8, 32'h2);
    expect_val("R7", int'(frz_out), LIVE);
    @(negedge clk); cop_halted = 1'b0;
    @(negedge clk); expect_val("R7", int'(frz_out), 0);

    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bus_addr      = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) bus_addr = 4'h0;
      bus_wr        = ($urandom_range(0, 2) == 0);
      bus_wdata     = $urandom;
      sys_halted    = ($urandom_range(0, 4) == 0);
      cop_halted    = ($urandom_range(0, 4) == 0);
      wdog_nmi_mode = $urandom_range(0, 1) == 1;
    end
    @(negedge clk);
    bus_wr = 1'b0; sys_halted = 1'b0; cop_halted = 1'b0;
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule